// File: doc/BRIEF.md
# Clock-Slave Synchronous Serial Transmitter

This block sends 8-bit or 9-bit words on a single data line, paced by a shift clock that an external master drives. The host places words into a one-entry holding stage through a valid/ready write port. A word moves into the shift register as soon as the shifter is free. Bits leave least significant first. Each new bit is put on the line after a falling edge of the external clock, so the master samples it on the rising edge.

The holding stage and the shifter form a two-deep queue. The holding-empty flag drops when the host writes a word. It rises again only when that word moves into the shifter. Because the external clock alone paces the shifting, a word queued behind a busy shifter moves into the shifter with no host action. At that point the flag and the interrupt request rise.

The block transmits only when four conditions hold: synchronous operation is selected, the clock source is external, both receive enables are clear, and the port and transmit enables are set. In any other setting it releases the data line. It also drops any queued or partly sent word.

Top module: `sync_slave_tx`

## Requirements
- R1: `sdo_oe` is 1 only while `port_en`=1, `tx_en`=1, `sync_mode`=1, `clk_src_master`=0, `rx_single_en`=0 and `rx_cont_en`=0 all hold. Any other combination sets `sdo_oe` and `wr_ready` to 0.
- R2: `wr_ready` is 1 exactly when the block is active (the R1 condition) and the holding stage is empty, that is, when `hold_empty`=1.
- R3: When the shifter is idle, a word accepted at clock edge k moves into the shifter at edge k+1. `hold_empty` is 0 for the single cycle between those edges, then returns to 1 while `shift_empty` goes to 0.
- R4: Bits leave least significant first. Bit 0 is on `sdo` before the first rising edge of `sck_in`. `sdo` changes only after a falling edge of `sck_in` that follows a rising edge, and never while `sck_in` is high.
- R5: A word written while the shifter is busy stays in the holding stage. `hold_empty` and `wr_ready` stay 0 until the last bit of the current word has been shifted.
- R6: The falling edge that ends a word moves the held word into the shifter. `hold_empty` rises at that point, and the next word's bit 0 appears on `sdo` with no idle bit in between.
- R7: When `nine_bit_en`=1 at the time of a write, the frame has nine bits. The ninth bit, sent last, is the value of the bit register loaded by `bit9_we`/`bit9_d` at the time the low byte was written. When `nine_bit_en`=0 the frame has eight bits.
- R8: `irq` is 1 exactly when `hold_empty`=1 and `irq_en`=1.
- R9: `shift_empty` is 1 whenever no word is being shifted. While no word is being shifted, `sdo` rests at 1.
- R10: Taking the block out of the active state (R1) empties both stages within one clock. `hold_empty`=1, `shift_empty`=1 and `sdo`=1 follow. External clocks that arrive afterwards send nothing.
- R11: A write is taken only on a clock edge where `wr_valid` and `wr_ready` are both 1. A `wr_valid` pulse while `wr_ready`=0 changes nothing that is later sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the shift clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Serial port enable |
| tx_en | input | 1 | Transmit enable |
| sync_mode | input | 1 | 1 selects synchronous operation |
| clk_src_master | input | 1 | 1 means the block would drive the clock; must be 0 to transmit |
| rx_single_en | input | 1 | Single-word receive enable; 1 blocks transmission |
| rx_cont_en | input | 1 | Continuous receive enable; 1 blocks transmission |
| nine_bit_en | input | 1 | 1 selects 9-bit frames for the next written word |
| bit9_we | input | 1 | Load strobe for the ninth-bit register |
| bit9_d | input | 1 | Value loaded into the ninth-bit register |
| wr_valid | input | 1 | Host offers a low byte |
| wr_ready | output | 1 | Holding stage can take a word |
| wr_data | input | DATA_W | Low data bits of the word |
| sck_in | input | 1 | Shift clock from the external master |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Data line drive enable |
| hold_empty | output | 1 | Holding stage empty flag |
| shift_empty | output | 1 | Shifter idle status |
| irq_en | input | 1 | Interrupt enable for the empty flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the rules that hold on every cycle. The output drive needs the full transmit configuration. An interrupt request needs both the flag and the enable. The ready signal never rises while a word is held. An idle shifter leaves the line high. Leaving the active state empties both stages on the next cycle. `sdo` moves only on a detected falling edge or a load. An accepted word reaches an idle shifter one cycle later. Only the directed scenarios can show the order of the bits and the full content of the frames. They also show that a queued word follows with no gap, that the ninth bit is latched when the word is written, that writes without ready are dropped, and that clocks arriving after an abort send nothing.

// File: rtl/sst_pkg.sv
package sst_pkg;

  // Fewest flops allowed in the shift-clock synchronizer.
  localparam int unsigned SST_MIN_SYNC = 2;

  // Index of the final bit of a frame, 8-bit or 9-bit.
  function automatic int unsigned sst_last_index(input logic wide, input int unsigned data_w);
    return wide ? data_w : data_w - 1;
  endfunction

endpackage

// File: rtl/sst_edge_sync.sv
module sst_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  import sst_pkg::*;

  localparam int unsigned N = (STAGES < SST_MIN_SYNC) ? SST_MIN_SYNC : STAGES;

  // chain[N-1] is the synchronized level; chain[N] holds its previous value.
  logic [N:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[N-1:0], async_in};
  end

  assign rise = chain[N-1] & ~chain[N];
  assign fall = ~chain[N-1] & chain[N];
endmodule

// File: rtl/sst_holding.sv
module sst_holding #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              bit9_we,
  input  logic              bit9_d,
  input  logic              wide_mode,
  input  logic              wr_fire,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W:0]   word,
  output logic              wide
);
  logic top_bit;

  // The ninth-bit register keeps its value across aborts; it is host setup.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       top_bit <= 1'b0;
    else if (bit9_we) top_bit <= bit9_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      word <= '0;
      wide <= 1'b0;
    end else if (!active) begin
      full <= 1'b0;
    end else if (wr_fire) begin
      full <= 1'b1;
      word <= {top_bit, wr_data};
      wide <= wide_mode;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            rise,
  input  logic            fall,
  input  logic            hold_full,
  input  logic [DATA_W:0] hold_word,
  input  logic            hold_wide,
  output logic            take,
  output logic            busy,
  output logic            sdo_bit
);
  import sst_pkg::*;

  localparam int unsigned FRAME_W = DATA_W + 1;
  localparam int unsigned CNT_W   = $clog2(FRAME_W);

  logic [DATA_W:0] shreg;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             rise_seen;
  logic             step;
  logic             done;

  // A falling edge only counts once the master has sampled on a rising edge.
  assign step = busy & fall & rise_seen;
  assign done = step & (cnt == last);
  assign take = active & hold_full & (~busy | done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      cnt       <= '0;
      last      <= '0;
      busy      <= 1'b0;
      rise_seen <= 1'b0;
    end else if (!active) begin
      shreg     <= '0;
      cnt       <= '0;
      busy      <= 1'b0;
      rise_seen <= 1'b0;
    end else if (take) begin
      shreg     <= hold_word;
      last      <= CNT_W'(sst_last_index(hold_wide, DATA_W));
      cnt       <= '0;
      busy      <= 1'b1;
      rise_seen <= 1'b0;
    end else if (done) begin
      busy      <= 1'b0;
      rise_seen <= 1'b0;
    end else if (step) begin
      shreg     <= {1'b0, shreg[DATA_W:1]};
      cnt       <= cnt + 1'b1;
      rise_seen <= 1'b0;
    end else if (busy && rise) begin
      rise_seen <= 1'b1;
    end
  end

  assign sdo_bit = busy ? shreg[0] : 1'b1;
endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              tx_en,
  input  logic              sync_mode,
  input  logic              clk_src_master,
  input  logic              rx_single_en,
  input  logic              rx_cont_en,
  input  logic              nine_bit_en,
  input  logic              bit9_we,
  input  logic              bit9_d,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sck_in,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              hold_empty,
  output logic              shift_empty,
  input  logic              irq_en,
  output logic              irq
);
  logic active;
  logic sck_rise, sck_fall;
  logic hold_full, hold_wide, xfer, busy, sh_bit;
  logic [DATA_W:0] hold_word;
  logic wr_fire;

  assign active = port_en & tx_en & sync_mode & ~clk_src_master
                & ~rx_single_en & ~rx_cont_en;

  assign wr_ready = active & ~hold_full;
  assign wr_fire  = wr_valid & wr_ready;

  sst_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (sck_in),
    .rise     (sck_rise),
    .fall     (sck_fall)
  );

  sst_holding #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .bit9_we   (bit9_we),
    .bit9_d    (bit9_d),
    .wide_mode (nine_bit_en),
    .wr_fire   (wr_fire),
    .wr_data   (wr_data),
    .take      (xfer),
    .full      (hold_full),
    .word      (hold_word),
    .wide      (hold_wide)
  );

  sst_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .rise      (sck_rise),
    .fall      (sck_fall),
    .hold_full (hold_full),
    .hold_word (hold_word),
    .hold_wide (hold_wide),
    .take      (xfer),
    .busy      (busy),
    .sdo_bit   (sh_bit)
  );

  assign sdo         = sh_bit;
  assign sdo_oe      = active;
  assign hold_empty  = ~hold_full;
  assign shift_empty = ~busy;
  assign irq         = hold_empty & irq_en;
endmodule

// File: rtl/sst_checker.sv
module sst_checker (
  input logic clk,
  input logic rst_n,
  input logic port_en,
  input logic tx_en,
  input logic sync_mode,
  input logic clk_src_master,
  input logic rx_single_en,
  input logic rx_cont_en,
  input logic wr_valid,
  input logic wr_ready,
  input logic sdo,
  input logic sdo_oe,
  input logic hold_empty,
  input logic shift_empty,
  input logic irq_en,
  input logic irq,
  input logic sck_fall,
  input logic xfer
);
  logic act;
  assign act = port_en & tx_en & sync_mode & ~clk_src_master & ~rx_single_en & ~rx_cont_en;

  a_r1_drive_needs_tx_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> (port_en && tx_en && sync_mode && !clk_src_master && !rx_single_en && !rx_cont_en));

  a_r2_ready_only_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> hold_empty);

  a_r3_idle_load_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_valid && wr_ready, 2) && $past(shift_empty) && $past(act)) |-> !shift_empty);

  a_r4_sdo_moves_on_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(act) && act && !$past(sck_fall) && !$past(xfer) && !$past(shift_empty) && !shift_empty)
      |-> $stable(sdo));

  a_r8_irq_needs_flag_and_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && hold_empty));

  a_r9_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> sdo);

  a_r10_abort_empties: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> (hold_empty && shift_empty && sdo));
endmodule

bind sync_slave_tx sst_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .port_en        (port_en),
  .tx_en          (tx_en),
  .sync_mode      (sync_mode),
  .clk_src_master (clk_src_master),
  .rx_single_en   (rx_single_en),
  .rx_cont_en     (rx_cont_en),
  .wr_valid       (wr_valid),
  .wr_ready       (wr_ready),
  .sdo            (sdo),
  .sdo_oe         (sdo_oe),
  .hold_empty     (hold_empty),
  .shift_empty    (shift_empty),
  .irq_en         (irq_en),
  .irq            (irq),
  .sck_fall       (sck_fall),
  .xfer           (xfer)
);

// File: tb/sim_sync_slave_tx.sv
`timescale 1ns/1ps
module sim_sync_slave_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_en = 1'b1, tx_en = 1'b1, sync_mode = 1'b1, clk_src_master = 1'b0;
  logic rx_single_en = 1'b0, rx_cont_en = 1'b0, nine_bit_en = 1'b0;
  logic bit9_we = 1'b0, bit9_d = 1'b0, wr_valid = 1'b0, irq_en = 1'b0, sck_in = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic wr_ready, sdo, sdo_oe, hold_empty, shift_empty, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sync_slave_tx u0 (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .tx_en(tx_en), .sync_mode(sync_mode),
    .clk_src_master(clk_src_master), .rx_single_en(rx_single_en), .rx_cont_en(rx_cont_en),
    .nine_bit_en(nine_bit_en), .bit9_we(bit9_we), .bit9_d(bit9_d), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .sck_in(sck_in), .sdo(sdo), .sdo_oe(sdo_oe),
    .hold_empty(hold_empty), .shift_empty(shift_empty), .irq_en(irq_en), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic set_bit9(input logic v);
    @(negedge clk); bit9_we = 1'b1; bit9_d = v;
    @(negedge clk); bit9_we = 1'b0;
  endtask

  // Plays the external master: sample, raise, hold, check stable, lower, hold.
  task automatic master_clock(input int n, input string req, output logic [8:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      logic b;
      b = sdo;
      got[i] = b;
      sck_in = 1'b1;
      repeat (4) @(negedge clk);
      chk({req, " sdo stable while sck high"}, {31'd0, sdo}, {31'd0, b});
      sck_in = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R9 reset shift_empty", {31'd0, shift_empty}, 32'd1);
    chk("R9 reset sdo idle", {31'd0, sdo}, 32'd1);
    chk("R2 reset hold_empty", {31'd0, hold_empty}, 32'd1);
    chk("R8 reset irq off", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_config();
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      port_en = (k != 0); tx_en = (k != 1); sync_mode = (k != 2);
      clk_src_master = (k == 3); rx_single_en = (k == 4); rx_cont_en = (k == 5);
      #1;
      chk("R1 oe off outside tx config", {31'd0, sdo_oe}, 32'd0);
      chk("R1 ready off outside tx config", {31'd0, wr_ready}, 32'd0);
    end
    @(negedge clk);
    port_en = 1; tx_en = 1; sync_mode = 1; clk_src_master = 0; rx_single_en = 0; rx_cont_en = 0;
    #1;
    chk("R1 oe on in tx config", {31'd0, sdo_oe}, 32'd1);
    chk("R2 ready when empty and active", {31'd0, wr_ready}, 32'd1);
  endtask

  task automatic t_single();
    logic [8:0] got;
    write_byte(8'hA5);
    chk("R3 flag low during one cycle", {31'd0, hold_empty}, 32'd0);
    chk("R3 shifter still idle", {31'd0, shift_empty}, 32'd1);
    @(negedge clk);
    chk("R3 flag back high after load", {31'd0, hold_empty}, 32'd1);
    chk("R3 shifter busy after load", {31'd0, shift_empty}, 32'd0);
    master_clock(8, "R4", got);
    chk("R4 lsb-first word A5", {23'd0, got}, 32'h0A5);
    chk("R9 idle after word", {31'd0, shift_empty}, 32'd1);
    chk("R9 line high after word", {31'd0, sdo}, 32'd1);
  endtask

  task automatic t_back_to_back();
    logic [8:0] got;
    irq_en = 1'b1;
    write_byte(8'h96);
    @(negedge clk);
    write_byte(8'h3C);
    chk("R5 flag low while held", {31'd0, hold_empty}, 32'd0);
    chk("R5 ready low while held", {31'd0, wr_ready}, 32'd0);
    chk("R8 irq low with flag low", {31'd0, irq}, 32'd0);
    master_clock(4, "R5", got);
    chk("R5 flag still low mid word", {31'd0, hold_empty}, 32'd0);
    master_clock(4, "R5", got);
    chk("R6 flag high after handoff", {31'd0, hold_empty}, 32'd1);
    chk("R8 irq with flag and enable", {31'd0, irq}, 32'd1);
    chk("R6 no idle gap", {31'd0, shift_empty}, 32'd0);
    master_clock(8, "R6", got);
    chk("R6 second word 3C", {23'd0, got}, 32'h03C);
    chk("R9 idle after pair", {31'd0, shift_empty}, 32'd1);
    irq_en = 1'b0;
    #1;
    chk("R8 irq off without enable", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_ignored();
    logic [8:0] got;
    write_byte(8'h11);
    @(negedge clk);
    write_byte(8'h22);
    @(negedge clk); wr_valid = 1'b1; wr_data = 8'hEE;
    repeat (2) @(negedge clk); wr_valid = 1'b0;
    master_clock(8, "R11", got);
    chk("R11 first word intact", {23'd0, got}, 32'h011);
    master_clock(8, "R11", got);
    chk("R11 held word not overwritten", {23'd0, got}, 32'h022);
    chk("R11 extra write not queued", {31'd0, shift_empty}, 32'd1);
    @(negedge clk); rx_single_en = 1'b1; wr_valid = 1'b1; wr_data = 8'h77;
    @(negedge clk); wr_valid = 1'b0; rx_single_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 write in rx config dropped (hold)", {31'd0, hold_empty}, 32'd1);
    chk("R11 write in rx config dropped (shift)", {31'd0, shift_empty}, 32'd1);
  endtask

  task automatic t_nine();
    logic [8:0] got;
    nine_bit_en = 1'b1;
    set_bit9(1'b1);
    write_byte(8'h5A);
    set_bit9(1'b0);
    master_clock(9, "R7", got);
    chk("R7 ninth bit latched at write", {23'd0, got}, 32'h15A);
    write_byte(8'hFF);
    @(negedge clk);
    master_clock(9, "R7", got);
    chk("R7 ninth bit zero", {23'd0, got}, 32'h0FF);
    nine_bit_en = 1'b0;
    write_byte(8'h81);
    @(negedge clk);
    master_clock(8, "R7", got);
    chk("R7 eight-bit frame after mode off", {23'd0, got}, 32'h081);
    chk("R7 no ninth bit pending", {31'd0, shift_empty}, 32'd1);
  endtask

  task automatic t_abort();
    logic [8:0] got;
    write_byte(8'h00);
    @(negedge clk);
    write_byte(8'h00);
    master_clock(3, "R10", got);
    tx_en = 1'b0;
    @(negedge clk);
    chk("R10 hold emptied", {31'd0, hold_empty}, 32'd1);
    chk("R10 shifter emptied", {31'd0, shift_empty}, 32'd1);
    chk("R10 line idle", {31'd0, sdo}, 32'd1);
    chk("R1 drive released", {31'd0, sdo_oe}, 32'd0);
    tx_en = 1'b1;
    master_clock(8, "R10", got);
    chk("R10 nothing sent after abort", {23'd0, got}, 32'h0FF);
    chk("R10 stays idle", {31'd0, shift_empty}, 32'd1);
    write_byte(8'h3C);
    @(negedge clk); port_en = 1'b0;
    @(negedge clk); port_en = 1'b1;
    chk("R10 port disable empties", {31'd0, shift_empty}, 32'd1);
    write_byte(8'hC3);
    @(negedge clk);
    master_clock(8, "R10", got);
    chk("R10 recovery word", {23'd0, got}, 32'h0C3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_config();
    t_single();
    t_back_to_back();
    t_ignored();
    t_nine();
    t_abort();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1..all actual=timeout expected=done");
      summary();
      $finish;
    end
  end
endmodule